// File: doc/BRIEF.md
# Reorder Buffer with Register Rename Indirection

This block is the in-order retirement queue of a small pipeline whose instructions finish out of order. A decode stage asks for an entry and gets back a tag naming it; up to two completion ports later deliver results to entries by tag. The oldest entry retires on its own once its result is present. Retiring copies the result into an architectural register file kept inside the block.

A register status table keeps one pending bit and one producer tag for each architectural register. A source-operand read looks up this table and then reads the producer entry directly by tag, so no search across the queue is needed. When the oldest entry carries an exception flag, the block discards every entry. It clears all pending marks, and the architectural file keeps the state as of the last retired instruction.

Top module: `ooo_retire_queue`

## Requirements
- R1: After reset the queue is empty (`occupancy` = 0), `commit_vld` and `flush` are low, and reading any register gives `rd_ready` = 1 with `rd_data` = 0.
- R2: With `alloc_req` high, `occupancy` below the depth and no flush this cycle, `alloc_grant` is high. `alloc_tag` names the granted entry. Tags are handed out in program order: 0, 1, 2 and so on, wrapping from depth-1 back to 0. Each grant raises `occupancy` by one, unless a retirement happens in the same cycle.
- R3: When `occupancy` equals the depth (8 by default), `alloc_grant` stays low and `occupancy` does not change.
- R4: A completion on either port stores its data and exception flag in the entry named by its tag. It does not write the architectural file. Two completions in the same cycle to different tags both take effect.
- R5: Only the oldest entry retires, and only once it has completed. A younger completed entry does not raise `commit_vld`. `commit_vld`, `commit_reg` and `commit_data` show the retiring entry in the cycle after its completion, and the head then moves on.
- R6: A retirement writes `commit_data` into the architectural register. The register's pending mark is cleared only when its producer tag equals the tag of the retiring entry. Otherwise, reads keep returning the newer producer.
- R7: The read port returns `rd_ready` = 1 with the architectural value when the register is not pending, and `rd_ready` = 1 with the entry's value when its producer has completed. When the producer has not completed, it returns `rd_ready` = 0 with `rd_data` = the producer tag, zero-extended.
- R8: If the oldest entry completed with its exception flag set, then in the next cycle `flush` is high and `commit_vld` is low. At the following edge the queue empties, and every register reads ready with its last retired value. The next allocated tag is 0.
- R9: A grant in the same cycle as a retirement to the same register leaves that register pending on the new tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_req | input | 1 | Decode asks for an entry |
| alloc_dst | input | 3 | Destination register of the decoded instruction |
| alloc_grant | output | 1 | Entry granted this cycle |
| alloc_tag | output | 3 | Tag of the entry being granted |
| cpl_vld | input | 2 | Completion valid, one bit per port |
| cpl_tag | input | 6 | Completion tags, port p in bits [3p+2:3p] |
| cpl_data | input | 32 | Completion data, port p in bits [16p+15:16p] |
| cpl_exc | input | 2 | Completion exception flags, one per port |
| rd_reg | input | 3 | Source register to look up |
| rd_ready | output | 1 | Looked-up value is available |
| rd_data | output | 16 | Value, or zero-extended producer tag when not ready |
| commit_vld | output | 1 | Head entry retires this cycle |
| commit_reg | output | 3 | Register written by the retirement |
| commit_data | output | 16 | Value written by the retirement |
| flush | output | 1 | Head entry raised an exception; queue is discarded |
| occupancy | output | 4 | Number of entries in use |

## Verification
On every cycle, the assertions check the occupancy bound and the stall when the queue is full. They also check that tags advance by one per grant, that retirement and flush never coincide, and that nothing retires from an empty queue. The occupancy step on a lone grant or a lone retirement is checked the same way, as is the emptying and tag reset after a flush. Only the bench's scenarios can show data-dependent outcomes. These are the values returned through the rename lookup, the retention of a newer producer tag after an older one retires, and the restoration of retired values after a flush. They also include a same-cycle grant and retirement on one register.

// File: rtl/rq_pkg.sv
// Shared types for the retirement queue.
// Assumes nothing beyond IEEE 1800-2017 packages.
package rq_pkg;

    // What the head of the queue does this cycle.
    typedef enum logic [1:0] {
        HEAD_IDLE   = 2'd0,
        HEAD_COMMIT = 2'd1,
        HEAD_FLUSH  = 2'd2
    } head_act_e;

    // Where the read port takes its operand from.
    typedef enum logic [1:0] {
        SRC_ARCH  = 2'd0,
        SRC_ENTRY = 2'd1,
        SRC_WAIT  = 2'd2
    } rd_src_e;

endpackage

// File: rtl/rq_ctrl.sv
// Head/tail pointers, occupancy and head decision of the retirement queue.
// Assumes the entry store reports the head entry's valid/done/exception state
// from registers; a flush returns both pointers to zero.
module rq_ctrl
    import rq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int TAG_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_req,
    input  logic             head_valid,
    input  logic             head_done,
    input  logic             head_exc,
    output logic             grant,
    output logic [TAG_W-1:0] head,
    output logic [TAG_W-1:0] tail,
    output logic [CNT_W-1:0] count,
    output head_act_e        action
);

    // Decide whether the head retires, flushes or waits.
    always_comb begin
        action = HEAD_IDLE;
        if (head_valid && head_done)
            action = head_exc ? HEAD_FLUSH : HEAD_COMMIT;
    end

    // Grant only with room and no flush pending.
    always_comb grant = alloc_req && (count != CNT_W'(DEPTH)) && (action != HEAD_FLUSH);

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || action == HEAD_FLUSH) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (grant)
                tail <= (tail == TAG_W'(DEPTH - 1)) ? '0 : tail + 1'b1;
            if (action == HEAD_COMMIT)
                head <= (head == TAG_W'(DEPTH - 1)) ? '0 : head + 1'b1;
            count <= count + CNT_W'(grant) - CNT_W'(action == HEAD_COMMIT);
        end
    end

endmodule

// File: rtl/rq_entries.sv
// Entry storage of the retirement queue: valid, destination, value, done and
// exception flag per entry. Completions to entries not in use are dropped.
// When two ports name the same tag in one cycle, the higher port wins.
module rq_entries #(
    parameter int DEPTH  = 8,
    parameter int NREG   = 8,
    parameter int DATA_W = 16,
    parameter int NCPL   = 2,
    localparam int TAG_W = $clog2(DEPTH),
    localparam int REG_W = $clog2(NREG)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   alloc_en,
    input  logic [TAG_W-1:0]       alloc_tag,
    input  logic [REG_W-1:0]       alloc_dst,
    input  logic [NCPL-1:0]        cpl_vld,
    input  logic [NCPL*TAG_W-1:0]  cpl_tag,
    input  logic [NCPL*DATA_W-1:0] cpl_data,
    input  logic [NCPL-1:0]        cpl_exc,
    input  logic                   retire_en,
    input  logic                   flush,
    input  logic [TAG_W-1:0]       head_tag,
    output logic                   head_valid,
    output logic                   head_done,
    output logic                   head_exc,
    output logic [REG_W-1:0]       head_dst,
    output logic [DATA_W-1:0]      head_data,
    input  logic [TAG_W-1:0]       look_tag,
    output logic                   look_done,
    output logic [DATA_W-1:0]      look_data
);

    logic [DEPTH-1:0] ent_valid, ent_done, ent_exc;
    logic [REG_W-1:0]  ent_dst  [DEPTH];
    logic [DATA_W-1:0] ent_data [DEPTH];
    logic [DEPTH-1:0]  hit, hit_exc;
    logic [DATA_W-1:0] hit_data [DEPTH];

    // Match completion tags against every entry.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            hit[i]      = 1'b0;
            hit_exc[i]  = 1'b0;
            hit_data[i] = '0;
            for (int p = 0; p < NCPL; p++) begin
                if (cpl_vld[p] && cpl_tag[p*TAG_W +: TAG_W] == TAG_W'(i)) begin
                    hit[i]      = 1'b1;
                    hit_exc[i]  = cpl_exc[p];
                    hit_data[i] = cpl_data[p*DATA_W +: DATA_W];
                end
            end
        end
    end

    // Update entries on allocation, completion, retirement and flush.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n || flush) begin
                ent_valid[i] <= 1'b0;
                ent_done[i]  <= 1'b0;
                ent_exc[i]   <= 1'b0;
                if (!rst_n) begin
                    ent_dst[i]  <= '0;
                    ent_data[i] <= '0;
                end
            end else if (alloc_en && alloc_tag == TAG_W'(i)) begin
                ent_valid[i] <= 1'b1;
                ent_done[i]  <= 1'b0;
                ent_exc[i]   <= 1'b0;
                ent_dst[i]   <= alloc_dst;
            end else if (retire_en && head_tag == TAG_W'(i)) begin
                ent_valid[i] <= 1'b0;
                ent_done[i]  <= 1'b0;
            end else if (hit[i] && ent_valid[i]) begin
                ent_done[i] <= 1'b1;
                ent_exc[i]  <= hit_exc[i];
                ent_data[i] <= hit_data[i];
            end
        end
    end

    // Head and lookup read ports.
    always_comb begin
        head_valid = ent_valid[head_tag];
        head_done  = ent_done[head_tag];
        head_exc   = ent_exc[head_tag];
        head_dst   = ent_dst[head_tag];
        head_data  = ent_data[head_tag];
        look_done  = ent_valid[look_tag] && ent_done[look_tag];
        look_data  = ent_data[look_tag];
    end

endmodule

// File: rtl/rq_regstat.sv
// Architectural register file plus register status table (pending bit and
// producer tag per register). Assumes allocation and retirement to the same
// register in one cycle leave the new producer pending.
module rq_regstat #(
    parameter int DEPTH  = 8,
    parameter int NREG   = 8,
    parameter int DATA_W = 16,
    localparam int TAG_W = $clog2(DEPTH),
    localparam int REG_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_en,
    input  logic [REG_W-1:0]  alloc_dst,
    input  logic [TAG_W-1:0]  alloc_tag,
    input  logic              commit_en,
    input  logic [REG_W-1:0]  commit_reg,
    input  logic [TAG_W-1:0]  commit_tag,
    input  logic [DATA_W-1:0] commit_data,
    input  logic              flush,
    input  logic [REG_W-1:0]  rd_reg,
    output logic              rd_pending,
    output logic [TAG_W-1:0]  rd_ptag,
    output logic [DATA_W-1:0] rd_arch
);

    logic [DATA_W-1:0] arch [NREG];
    logic [NREG-1:0]   pend;
    logic [TAG_W-1:0]  ptag [NREG];

    // Write retired values and maintain the rename status.
    always_ff @(posedge clk) begin
        for (int r = 0; r < NREG; r++) begin
            if (!rst_n) begin
                arch[r] <= '0;
                pend[r] <= 1'b0;
                ptag[r] <= '0;
            end else begin
                if (commit_en && commit_reg == REG_W'(r))
                    arch[r] <= commit_data;
                if (flush)
                    pend[r] <= 1'b0;
                else if (alloc_en && alloc_dst == REG_W'(r)) begin
                    pend[r] <= 1'b1;
                    ptag[r] <= alloc_tag;
                end else if (commit_en && commit_reg == REG_W'(r) && ptag[r] == commit_tag)
                    pend[r] <= 1'b0;
            end
        end
    end

    // Status lookup for the operand read port.
    always_comb begin
        rd_pending = pend[rd_reg];
        rd_ptag    = ptag[rd_reg];
        rd_arch    = arch[rd_reg];
    end

endmodule

// File: rtl/ooo_retire_queue.sv
// Top of the reorder buffer with rename indirection: allocates entries in
// program order, accepts out-of-order completions, retires the oldest
// completed entry into the architectural file and flushes on an exception.
// Assumes the decoder holds alloc_req until granted.
module ooo_retire_queue
    import rq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int NREG   = 8,
    parameter int DATA_W = 16,
    parameter int NCPL   = 2,
    localparam int TAG_W = $clog2(DEPTH),
    localparam int REG_W = $clog2(NREG),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   alloc_req,
    input  logic [REG_W-1:0]       alloc_dst,
    output logic                   alloc_grant,
    output logic [TAG_W-1:0]       alloc_tag,
    input  logic [NCPL-1:0]        cpl_vld,
    input  logic [NCPL*TAG_W-1:0]  cpl_tag,
    input  logic [NCPL*DATA_W-1:0] cpl_data,
    input  logic [NCPL-1:0]        cpl_exc,
    input  logic [REG_W-1:0]       rd_reg,
    output logic                   rd_ready,
    output logic [DATA_W-1:0]      rd_data,
    output logic                   commit_vld,
    output logic [REG_W-1:0]       commit_reg,
    output logic [DATA_W-1:0]      commit_data,
    output logic                   flush,
    output logic [CNT_W-1:0]       occupancy
);

    head_act_e         action;
    rd_src_e           rd_src;
    logic [TAG_W-1:0]  head, tail, rd_ptag;
    logic              head_valid, head_done, head_exc, rd_pending, look_done;
    logic [DATA_W-1:0] rd_arch, look_data;

    rq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req),
        .head_valid(head_valid), .head_done(head_done), .head_exc(head_exc),
        .grant(alloc_grant), .head(head), .tail(tail), .count(occupancy),
        .action(action)
    );

    rq_entries #(.DEPTH(DEPTH), .NREG(NREG), .DATA_W(DATA_W), .NCPL(NCPL)) u_entries (
        .clk(clk), .rst_n(rst_n),
        .alloc_en(alloc_grant), .alloc_tag(tail), .alloc_dst(alloc_dst),
        .cpl_vld(cpl_vld), .cpl_tag(cpl_tag), .cpl_data(cpl_data), .cpl_exc(cpl_exc),
        .retire_en(commit_vld), .flush(flush), .head_tag(head),
        .head_valid(head_valid), .head_done(head_done), .head_exc(head_exc),
        .head_dst(commit_reg), .head_data(commit_data),
        .look_tag(rd_ptag), .look_done(look_done), .look_data(look_data)
    );

    rq_regstat #(.DEPTH(DEPTH), .NREG(NREG), .DATA_W(DATA_W)) u_regstat (
        .clk(clk), .rst_n(rst_n),
        .alloc_en(alloc_grant), .alloc_dst(alloc_dst), .alloc_tag(tail),
        .commit_en(commit_vld), .commit_reg(commit_reg), .commit_tag(head),
        .commit_data(commit_data), .flush(flush),
        .rd_reg(rd_reg), .rd_pending(rd_pending), .rd_ptag(rd_ptag), .rd_arch(rd_arch)
    );

    // Head action drives the retirement and flush outputs.
    always_comb begin
        commit_vld = (action == HEAD_COMMIT);
        flush      = (action == HEAD_FLUSH);
        alloc_tag  = tail;
    end

    // Choose the operand source from the status table and producer entry.
    always_comb begin
        if (!rd_pending)    rd_src = SRC_ARCH;
        else if (look_done) rd_src = SRC_ENTRY;
        else                rd_src = SRC_WAIT;
        case (rd_src)
            SRC_ARCH:  begin rd_ready = 1'b1; rd_data = rd_arch;          end
            SRC_ENTRY: begin rd_ready = 1'b1; rd_data = look_data;        end
            default:   begin rd_ready = 1'b0; rd_data = DATA_W'(rd_ptag); end
        endcase
    end

endmodule

// File: rtl/ooo_retire_queue_chk.sv
// Cycle-by-cycle properties of the retirement queue, bound to the top.
module ooo_retire_queue_chk #(
    parameter int DEPTH = 8,
    parameter int TAG_W = 3,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_grant,
    input logic [TAG_W-1:0] alloc_tag,
    input logic             commit_vld,
    input logic             flush,
    input logic [CNT_W-1:0] occupancy
);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= CNT_W'(DEPTH)); // R3
    AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy == CNT_W'(DEPTH) |-> !alloc_grant); // R3
    AST_TAG_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_grant |=> alloc_tag == (($past(alloc_tag) == TAG_W'(DEPTH - 1)) ? '0 : $past(alloc_tag) + 1'b1)); // R2
    AST_COUNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_grant && !commit_vld |=> occupancy == $past(occupancy) + 1'b1); // R2
    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        commit_vld && !alloc_grant |=> occupancy == $past(occupancy) - 1'b1); // R5
    AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy == '0 |-> !commit_vld && !flush); // R5
    AST_COMMIT_XOR_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_vld && flush)); // R8
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> occupancy == '0 && alloc_tag == '0); // R8

endmodule

bind ooo_retire_queue ooo_retire_queue_chk #(.DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .alloc_grant(alloc_grant), .alloc_tag(alloc_tag),
    .commit_vld(commit_vld), .flush(flush), .occupancy(occupancy)
);

// File: tb/ooo_retire_queue_bench.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module ooo_retire_queue_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_req = 1'b0;
    logic [2:0]  alloc_dst = '0;
    logic        alloc_grant;
    logic [2:0]  alloc_tag;
    logic [1:0]  cpl_vld = '0;
    logic [5:0]  cpl_tag = '0;
    logic [31:0] cpl_data = '0;
    logic [1:0]  cpl_exc = '0;
    logic [2:0]  rd_reg = '0;
    logic        rd_ready;
    logic [15:0] rd_data;
    logic        commit_vld;
    logic [2:0]  commit_reg;
    logic [15:0] commit_data;
    logic        flush;
    logic [3:0]  occupancy;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    ooo_retire_queue u_ooo_retire_queue (
        .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_dst(alloc_dst),
        .alloc_grant(alloc_grant), .alloc_tag(alloc_tag),
        .cpl_vld(cpl_vld), .cpl_tag(cpl_tag), .cpl_data(cpl_data), .cpl_exc(cpl_exc),
        .rd_reg(rd_reg), .rd_ready(rd_ready), .rd_data(rd_data),
        .commit_vld(commit_vld), .commit_reg(commit_reg), .commit_data(commit_data),
        .flush(flush), .occupancy(occupancy)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic read_reg(input int r, input int rdy, input int data, input string what);
        rd_reg = 3'(r);
        #0.5;
        chk({what, " ready"}, int'(rd_ready), rdy);
        chk({what, " data"}, int'(rd_data), data);
    endtask

    task automatic do_alloc(input int r, input int tag, input string what);
        alloc_req = 1'b1;
        alloc_dst = 3'(r);
        #0.5;
        chk({what, " grant"}, int'(alloc_grant), 1);
        chk({what, " tag"}, int'(alloc_tag), tag);
        tick();
        alloc_req = 1'b0;
    endtask

    task automatic complete(input int port, input int tag, input int data, input bit exc);
        cpl_vld[port]            = 1'b1;
        cpl_tag[port*3 +: 3]     = 3'(tag);
        cpl_data[port*16 +: 16]  = 16'(data);
        cpl_exc[port]            = exc;
    endtask

    task automatic cpl_tick();
        tick();
        cpl_vld = '0;
        cpl_exc = '0;
        #0.5;
    endtask

    task automatic expect_commit(input int r, input int data, input string what);
        chk({what, " commit_vld"}, int'(commit_vld), 1);
        chk({what, " commit_reg"}, int'(commit_reg), r);
        chk({what, " commit_data"}, int'(commit_data), data);
    endtask

    task automatic t_reset();
        chk("R1 occupancy", int'(occupancy), 0);
        chk("R1 commit_vld", int'(commit_vld), 0);
        chk("R1 flush", int'(flush), 0);
        for (int r = 0; r < 8; r++) read_reg(r, 1, 0, "R1 reg");
    endtask

    task automatic t_basic();
        do_alloc(3, 0, "R2 first");
        read_reg(3, 0, 0, "R7 waiting tag0");
        do_alloc(5, 1, "R2 second");
        complete(1, 1, 'h55, 1'b0);
        cpl_tick();
        chk("R5 younger done no commit", int'(commit_vld), 0);
        read_reg(5, 1, 'h55, "R7 from entry");
        read_reg(3, 0, 0, "R4 not in arch");
        complete(0, 0, 'h33, 1'b0);
        cpl_tick();
        expect_commit(3, 'h33, "R5 head");
        tick();
        expect_commit(5, 'h55, "R5 next");
        chk("R5 occupancy", int'(occupancy), 1);
        tick();
        chk("R5 idle", int'(commit_vld), 0);
        chk("R5 empty", int'(occupancy), 0);
        read_reg(3, 1, 'h33, "R6 arch r3");
        read_reg(5, 1, 'h55, "R6 arch r5");
    endtask

    task automatic t_rename();
        do_alloc(1, 2, "R2 r1 older");
        do_alloc(1, 3, "R2 r1 newer");
        complete(0, 2, 'h11, 1'b0);
        cpl_tick();
        expect_commit(1, 'h11, "R6 older");
        tick();
        read_reg(1, 0, 3, "R6 newer tag kept");
        complete(1, 3, 'h22, 1'b0);
        cpl_tick();
        expect_commit(1, 'h22, "R6 newer");
        tick();
        read_reg(1, 1, 'h22, "R6 cleared");
    endtask

    task automatic t_dual();
        do_alloc(2, 4, "R2 r2");
        do_alloc(4, 5, "R2 r4");
        complete(0, 5, 'h45, 1'b0);
        complete(1, 4, 'h24, 1'b0);
        cpl_tick();
        expect_commit(2, 'h24, "R4 port1");
        tick();
        expect_commit(4, 'h45, "R4 port0");
        tick();
        chk("R4 empty", int'(occupancy), 0);
    endtask

    task automatic t_same_cycle();
        do_alloc(6, 6, "R9 first");
        complete(0, 6, 'h66, 1'b0);
        cpl_tick();
        expect_commit(6, 'h66, "R9 retiring");
        do_alloc(6, 7, "R9 realloc");
        read_reg(6, 0, 7, "R9 new tag pending");
        complete(0, 7, 'h77, 1'b0);
        cpl_tick();
        expect_commit(6, 'h77, "R9 second");
        tick();
        read_reg(6, 1, 'h77, "R9 arch");
    endtask

    task automatic t_full();
        for (int i = 0; i < 8; i++) do_alloc(i, i, "R2 wrap fill");
        chk("R3 occupancy full", int'(occupancy), 8);
        alloc_req = 1'b1;
        alloc_dst = 3'd0;
        #0.5;
        chk("R3 no grant", int'(alloc_grant), 0);
        tick();
        alloc_req = 1'b0;
        chk("R3 occupancy held", int'(occupancy), 8);
    endtask

    task automatic t_flush();
        complete(0, 0, 'hEE, 1'b1);
        complete(1, 1, 'hAA, 1'b0);
        cpl_tick();
        chk("R8 flush", int'(flush), 1);
        chk("R8 no commit", int'(commit_vld), 0);
        tick();
        chk("R8 flush done", int'(flush), 0);
        chk("R8 empty", int'(occupancy), 0);
        read_reg(0, 1, 0, "R8 r0 restored");
        read_reg(1, 1, 'h22, "R8 r1 restored");
        read_reg(6, 1, 'h77, "R8 r6 restored");
        read_reg(7, 1, 0, "R8 r7 restored");
        do_alloc(2, 0, "R8 tag restart");
        complete(0, 0, 'h99, 1'b0);
        cpl_tick();
        expect_commit(2, 'h99, "R8 after flush");
        tick();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #0.5;
        t_reset();
        t_basic();
        t_rename();
        t_dual();
        t_same_cycle();
        t_full();
        t_flush();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule